// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Timing Engine

This block is the lowest layer of a master for a single-wire, open-drain serial bus. It turns one command into one timed waveform on the line: a bus reset with a presence check, a write-0 slot, a write-1 slot, or a read slot. It drives a pull-down enable and reads the line back through a two-flop synchronizer. All timing is counted in microseconds. The microsecond tick comes from a prescaler on the system clock, and that prescaler restarts each time a command is accepted, so every window sits at a fixed number of clocks from the accept edge.

Higher layers issue one command whenever `busy` is low and wait for the one-clock `done` pulse. They then read `presence` after a reset or `read_bit` after a read. Both values hold until the next operation of the same kind. The engine never holds the line low for long except during a reset.

Top module: `ow_slot_engine`

## Requirements
- R1: During and right after synchronous active-low reset, `busy`, `done`, `drive_low`, `presence` and `read_bit` are all 0.
- R2: A command on `cmd` is accepted at a clock edge where `cmd_valid` is 1 and `busy` is 0. A request made while `busy` is 1 is ignored: the running operation keeps its timing and nothing starts after it. Encodings: 0 = bus reset, 1 = write 0, 2 = write 1, 3 = read.
- R3: A bus reset drives `drive_low` for RST_LOW_US (480) microseconds, starting at the accept edge.
- R4: A bus reset samples the synchronized line RST_LOW_US + PRES_US (480 + 70) microseconds after the accept edge. `presence` becomes 1 if the line is low at that point and 0 if it is high.
- R5: A bus reset ends, with `busy` falling, RST_LOW_US + RST_HIGH_US (480 + 480) microseconds after the accept edge.
- R6: A write-0 slot drives the line low for W0_LOW_US (65) microseconds. A write-1 slot drives it low for W1_LOW_US (6) microseconds.
- R7: A read slot drives the line low for RD_LOW_US (3) microseconds. `read_bit` takes the synchronized line level RD_SAMPLE_US (12) microseconds after the accept edge.
- R8: Each write or read slot lasts SLOT_US + REC_US (70 + 2) microseconds, and the line is released for the whole tail of the slot.
- R9: `done` is a single-clock pulse in the first cycle in which `busy` is low again. `busy` is high from the accept edge through the last clock of the operation.
- R10: Outside a bus reset, `drive_low` never stays high for more than 120 microseconds in a row.
- R11: `presence` changes only through a bus reset and `read_bit` only through a read. Both hold their values while the engine is idle.
- R12: One microsecond is CLK_PER_US clocks, counted from the accept edge, so every window above lasts exactly its microsecond count times CLK_PER_US clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd | input | 2 | Operation code (0 reset, 1 write 0, 2 write 1, 3 read) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse at the end of an operation |
| drive_low | output | 1 | Pull-down enable for the open-drain line |
| line_in | input | 1 | Line level as seen at the pad (asynchronous) |
| presence | output | 1 | A device answered the last bus reset |
| read_bit | output | 1 | Value from the last read slot |

## Verification
Two things can happen in the same cycle: an operation finishing, with its `done` pulse and `busy` falling, and a waiting command request being accepted. The bench provokes this by holding `cmd_valid` high for a write-1 through the whole of a write-0 slot. It then checks three things: `busy` is low for exactly the `done` cycle, the new slot's pull-down starts on the next edge, and that slot keeps its full low time. A second provocation pulses a request in the middle of a slot. Here the bench checks that the slot timing does not change and that nothing starts once the slot ends.

// File: rtl/ow_slot_pkg.sv
// Shared operation codes for the single-wire slot timing engine.
// Assumes the code values below are the ones a command issuer drives.
package ow_slot_pkg;
    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WR0   = 2'd1,
        OP_WR1   = 2'd2,
        OP_READ  = 2'd3
    } ow_op_e;
endpackage

// File: rtl/ow_sync.sv
// Multi-flop synchronizer for the asynchronous line level.
// Assumes the input may change at any time relative to clk; resets to the idle-high level.
module ow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One synchronizer stage; stage 0 takes the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= 1'b1;
                else if (s == 0)
                    chain[s] <= d_async;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ow_us_tick.sv
// Microsecond prescaler: pulses tick once every CLK_PER_US clocks while run is high.
// Assumes restart is asserted at the edge an operation is accepted, so the phase is fixed.
module ow_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count clocks within the current microsecond, wrapping at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (run)
            cnt <= tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/ow_slot_seq.sv
// Slot sequencer: holds the active operation, counts microseconds and drives the
// pull-down, the sample strobes and the end-of-operation handshake.
// Assumes start is only asserted while busy is low and that each window limit is
// at least 1 and smaller than the operation length.
module ow_slot_seq
    import ow_slot_pkg::*;
#(
    parameter int RST_LOW_US   = 480,
    parameter int PRES_US      = 70,
    parameter int RST_HIGH_US  = 480,
    parameter int W0_LOW_US    = 65,
    parameter int W1_LOW_US    = 6,
    parameter int RD_LOW_US    = 3,
    parameter int RD_SAMPLE_US = 12,
    parameter int SLOT_US      = 70,
    parameter int REC_US       = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  ow_op_e op_in,
    input  logic   tick,
    input  logic   line_s,
    output logic   busy,
    output logic   done,
    output logic   drive_low,
    output logic   presence,
    output logic   read_bit
);
    localparam int RST_END  = RST_LOW_US + RST_HIGH_US;
    localparam int SLOT_END = SLOT_US + REC_US;
    localparam int MAX_END  = (RST_END > SLOT_END) ? RST_END : SLOT_END;
    localparam int UW       = $clog2(MAX_END + 1);

    ow_op_e         op_q;
    logic [UW-1:0]  us_cnt;
    logic [UW-1:0]  low_last, samp_last, end_last;
    logic           samp_en, low_hit, samp_hit, end_hit;

    // Pick the window limits (last microsecond index) for the active operation.
    always_comb begin
        low_last  = UW'(SLOT_END - 1);
        samp_last = UW'(SLOT_END - 1);
        end_last  = UW'(SLOT_END - 1);
        samp_en   = 1'b0;
        case (op_q)
            OP_RESET: begin
                low_last  = UW'(RST_LOW_US - 1);
                samp_last = UW'(RST_LOW_US + PRES_US - 1);
                end_last  = UW'(RST_END - 1);
                samp_en   = 1'b1;
            end
            OP_WR0:  low_last = UW'(W0_LOW_US - 1);
            OP_WR1:  low_last = UW'(W1_LOW_US - 1);
            default: begin
                low_last  = UW'(RD_LOW_US - 1);
                samp_last = UW'(RD_SAMPLE_US - 1);
                samp_en   = 1'b1;
            end
        endcase
    end

    assign low_hit  = busy && tick && (us_cnt == low_last);
    assign samp_hit = busy && tick && samp_en && (us_cnt == samp_last);
    assign end_hit  = busy && tick && (us_cnt == end_last);

    // Operation control: accept, count microseconds, release the line, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_RESET;
            us_cnt    <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            drive_low <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                op_q      <= op_in;
                us_cnt    <= '0;
                busy      <= 1'b1;
                drive_low <= 1'b1;
            end else if (busy) begin
                if (tick)
                    us_cnt <= us_cnt + 1'b1;
                if (low_hit)
                    drive_low <= 1'b0;
                if (end_hit) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Capture the sampled line level into the result of the matching operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presence <= 1'b0;
            read_bit <= 1'b0;
        end else if (samp_hit) begin
            if (op_q == OP_RESET)
                presence <= !line_s;
            else
                read_bit <= line_s;
        end
    end
endmodule

// File: rtl/ow_slot_engine.sv
// Top of the single-wire bus master slot timing engine: command accept, microsecond
// prescaler, line synchronizer and slot sequencer.
// Assumes drive_low goes to an external open-drain pull-down and line_in is the pad level.
module ow_slot_engine
    import ow_slot_pkg::*;
#(
    parameter int CLK_PER_US   = 50,
    parameter int SYNC_STAGES  = 2,
    parameter int RST_LOW_US   = 480,
    parameter int PRES_US      = 70,
    parameter int RST_HIGH_US  = 480,
    parameter int W0_LOW_US    = 65,
    parameter int W1_LOW_US    = 6,
    parameter int RD_LOW_US    = 3,
    parameter int RD_SAMPLE_US = 12,
    parameter int SLOT_US      = 70,
    parameter int REC_US       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    output logic       busy,
    output logic       done,
    output logic       drive_low,
    input  logic       line_in,
    output logic       presence,
    output logic       read_bit
);
    logic accept, tick, line_s;

    // Accept a new command only while idle.
    assign accept = cmd_valid && !busy;

    ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(line_in), .q_sync(line_s)
    );

    ow_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy), .tick(tick)
    );

    ow_slot_seq #(
        .RST_LOW_US(RST_LOW_US), .PRES_US(PRES_US), .RST_HIGH_US(RST_HIGH_US),
        .W0_LOW_US(W0_LOW_US), .W1_LOW_US(W1_LOW_US), .RD_LOW_US(RD_LOW_US),
        .RD_SAMPLE_US(RD_SAMPLE_US), .SLOT_US(SLOT_US), .REC_US(REC_US)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .op_in(ow_op_e'(cmd)),
        .tick(tick), .line_s(line_s), .busy(busy), .done(done),
        .drive_low(drive_low), .presence(presence), .read_bit(read_bit)
    );
endmodule

// File: rtl/ow_slot_engine_chk.sv
// Protocol checker for ow_slot_engine, attached by bind. Watches only the ports.
// Assumes CLK_PER_US matches the bound instance.
module ow_slot_engine_chk #(
    parameter int CLK_PER_US = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd,
    input logic       busy,
    input logic       done,
    input logic       drive_low,
    input logic       presence,
    input logic       read_bit
);
    localparam int LOW_LIMIT = 120 * CLK_PER_US;

    logic        in_reset_op;
    logic [31:0] low_run;

    // Remember whether the running operation is a bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_reset_op <= 1'b0;
        else if (cmd_valid && !busy)
            in_reset_op <= (cmd == 2'd0);
    end

    // Count consecutive clocks of pull-down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (!drive_low)
            low_run <= '0;
        else if (low_run != 32'hFFFF_FFFF)
            low_run <= low_run + 1'b1;
    end

    // R2
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (busy && drive_low));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    low_inside_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> busy);

    // R10
    low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && !in_reset_op) |-> (low_run < LOW_LIMIT));

    // R11
    presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(presence));

    // R11
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(read_bit));
endmodule

bind ow_slot_engine ow_slot_engine_chk #(.CLK_PER_US(CLK_PER_US)) u_chk (.*);

// File: tb/ow_slot_engine_test.sv
// Bench for ow_slot_engine: sweeps every operation against both device answers at
// 4 clocks per microsecond; expected windows are products of microseconds and clocks.
module ow_slot_engine_test;
    localparam int N        = 4;
    localparam int RST_LOW  = 480;
    localparam int PRES     = 70;
    localparam int RST_HIGH = 480;
    localparam int W0       = 65;
    localparam int W1       = 6;
    localparam int RD_LOW   = 3;
    localparam int RD_SAMP  = 12;
    localparam int SLOT     = 70;
    localparam int REC      = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic       busy, done, drive_low, presence, read_bit;
    logic       dev_pull = 1'b0;
    logic       line_in;

    int checks = 0;
    int fails  = 0;
    int exp_pres = 0;
    int exp_rd   = 0;

    always #2 clk = !clk;

    // Wired-AND line: low when master or device pulls.
    assign line_in = !(drive_low || dev_pull);

    ow_slot_engine #(.CLK_PER_US(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .busy(busy), .done(done), .drive_low(drive_low), .line_in(line_in),
        .presence(presence), .read_bit(read_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int low_us(input int op);
        case (op)
            0: return RST_LOW;
            1: return W0;
            2: return W1;
            default: return RD_LOW;
        endcase
    endfunction

    function automatic int end_us(input int op);
        return (op == 0) ? RST_LOW + RST_HIGH : SLOT + REC;
    endfunction

    // Device answer: presence pulse after reset, or a zero during a read.
    function automatic logic model(input int op, input int dbit, input int us);
        if (op == 0) return (dbit == 1) && us >= RST_LOW + 15 && us < RST_LOW + 150;
        if (op == 3) return (dbit == 0) && us < 30;
        return 1'b0;
    endfunction

    // Observe one operation from index 0 (the negedge after its accept edge).
    task automatic measure(input int op, input int dbit, input int inject_at,
                           output int lowc, output int busyc, output int doneidx);
        int j = 0;
        lowc = 0; busyc = 0; doneidx = -1;
        while (doneidx < 0 && j < 6000) begin
            if (drive_low) lowc++;
            if (busy) busyc++;
            if (done) doneidx = j;
            dev_pull = model(op, dbit, j / N);
            if (inject_at >= 0) cmd_valid = (j == inject_at);
            if (inject_at >= 0 && j == inject_at) cmd = 2'((op + 1) % 4);
            if (doneidx < 0) begin
                @(negedge clk);
                j++;
            end
        end
        dev_pull = 1'b0;
    endtask

    task automatic run_op(input int op, input int dbit, input int inject_at);
        int lowc, busyc, doneidx;
        string tag;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd = 2'(op);
        @(negedge clk);
        cmd_valid = 1'b0;
        measure(op, dbit, inject_at, lowc, busyc, doneidx);
        tag = (op == 0) ? "R3 R12 reset low" : (op == 3) ? "R7 R12 read low" : "R6 R12 write low";
        check(lowc == low_us(op) * N, tag, lowc, low_us(op) * N);
        tag = (op == 0) ? "R5 reset length" : "R8 slot length";
        check(doneidx == end_us(op) * N, tag, doneidx, end_us(op) * N);
        check(busyc == end_us(op) * N, "R9 busy span", busyc, end_us(op) * N);
        if (op != 0)
            check(lowc <= 120 * N, "R10 low bound", lowc, 120 * N);
        if (op == 0) exp_pres = dbit;
        if (op == 3) exp_rd = dbit;
        check(presence == exp_pres, (op == 0) ? "R4 presence" : "R11 presence hold",
              presence, exp_pres);
        check(read_bit == exp_rd, (op == 3) ? "R7 read value" : "R11 read hold",
              read_bit, exp_rd);
        @(negedge clk);
        check(done == 1'b0, "R9 done width", done, 0);
        check(busy == 1'b0 && drive_low == 1'b0, "R2 nothing started", busy, 0);
        if (inject_at >= 0) begin
            repeat (2) @(negedge clk);
            check(busy == 1'b0, "R2 ignored request", busy, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lowc, busyc, doneidx;
        repeat (4) @(negedge clk);
        check(busy == 0 && done == 0 && drive_low == 0, "R1 reset outputs", busy, 0);
        check(presence == 0 && read_bit == 0, "R1 reset results", presence, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && drive_low == 0, "R1 idle after reset", drive_low, 0);

        // Sweep every operation against both device answers, twice over.
        for (int rep = 0; rep < 2; rep++)
            for (int op = 0; op < 4; op++)
                for (int d = 0; d < 2; d++)
                    run_op(op, (rep == 0) ? d : 1 - d, -1);

        // Requests during a busy slot must leave the slot unchanged (R2).
        run_op(1, 0, 10);
        run_op(3, 1, 5);
        run_op(2, 0, 20);

        // End of one slot and a waiting request in the same cycle window (R2, R9).
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd = 2'd1;
        @(negedge clk);
        cmd = 2'd2;
        measure(1, 0, -1, lowc, busyc, doneidx);
        check(doneidx == (SLOT + REC) * N, "R8 back-to-back first", doneidx, (SLOT + REC) * N);
        check(busy == 1'b0, "R9 idle at done", busy, 0);
        @(negedge clk);
        check(busy == 1'b1 && drive_low == 1'b1, "R2 accept after done", drive_low, 1);
        cmd_valid = 1'b0;
        measure(2, 0, -1, lowc, busyc, doneidx);
        check(lowc == W1 * N, "R6 back-to-back write-1 low", lowc, W1 * N);
        check(doneidx == (SLOT + REC) * N, "R8 back-to-back second", doneidx, (SLOT + REC) * N);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule